// File: doc/BRIEF.md
# Serial Bus Command Word Decoder

This block sits behind the word receiver of a remote terminal on a dual-redundant serial data bus. Each time the receiver presents a 16-bit command word it has already judged valid, the decoder checks the address field against the terminal's hardwired address. It also accepts the broadcast address when broadcast support is switched on. It then decides whether the terminal must act on the command.

On a match the block captures the direction bit, the subaddress and the word-count/mode-code field. It classifies the command as a receive transfer, a transmit transfer or a mode command, and turns the count field into an actual word count. It lowers an active-low in-command level for the life of the message and holds the published fields stable while that level is low. It also gives a one-clock active-low new-command pulse and records which bus carried the command.

A matching command that arrives on the other bus while a message is active abandons the current message. The block then switches to the new bus and flags the abandonment with a one-clock pulse. The protocol sequencer ends a message by raising a done strobe.

Top module: `cmdw_decoder`

## Requirements
- R1: While reset is held: in_cmd_n_o=1, new_cmd_n_o=1, abort_o=0, bus_sel_o=0, and tx_o, sa_o, wc_o, wcnt_o, kind_o and bcast_o are all zero.
- R2: A word strobed with word_vld_i=1 whose address field (bits 15:11) equals term_addr_i drives in_cmd_n_o low on the next clock and drives new_cmd_n_o low for exactly that one clock.
- R3: Address 31 is accepted as a broadcast only when bcast_en_i=1, and bcast_o=1 is then published. With bcast_en_i=0, a word addressed to 31 is ignored unless 31 is the terminal's own address.
- R4: A word with word_vld_i=0, or one whose address matches neither rule of R2 or R3, leaves every output unchanged, and new_cmd_n_o stays high.
- R5: On acceptance, tx_o takes bit 10, sa_o takes bits 9:5 and wc_o takes bits 4:0. These fields and bus_sel_o stay stable while in_cmd_n_o is low, until the next accepted command.
- R6: Subaddress 0 or 31 gives kind_o=2 (mode). Any other subaddress gives kind_o=1 when tx_o=1 (transmit data) and kind_o=0 when tx_o=0 (receive data).
- R7: For a data transfer, wcnt_o equals the count field, and a count field of zero gives 32. For a mode command, wcnt_o is 0.
- R8: msg_done_i=1 with no accepted word in the same cycle raises in_cmd_n_o on the next clock and leaves the fields unchanged.
- R9: A command accepted while in_cmd_n_o is low, on a bus_id_i different from bus_sel_o, switches bus_sel_o to the new bus and pulses abort_o high for one clock. in_cmd_n_o stays low.
- R10: A command accepted on the same bus while a message is active, or on any bus while idle, gives no abort pulse. It still reloads the fields and bus_sel_o and pulses new_cmd_n_o.
- R11: When an accepted word and msg_done_i occur in the same cycle, the new command wins and in_cmd_n_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld_i | input | 1 | One-cycle strobe: word_i holds a valid command word |
| word_i | input | 16 | Command word: address, direction, subaddress, count |
| bus_id_i | input | 1 | Bus on which word_i arrived |
| term_addr_i | input | 5 | Hardwired terminal address |
| bcast_en_i | input | 1 | Enables broadcast acceptance |
| msg_done_i | input | 1 | Sequencer signals end of the current message |
| in_cmd_n_o | output | 1 | Low while a command is being serviced |
| new_cmd_n_o | output | 1 | One-clock low pulse per accepted command |
| abort_o | output | 1 | One-clock pulse when a message is abandoned for another bus |
| bus_sel_o | output | 1 | Bus carrying the newest accepted command |
| tx_o | output | 1 | Direction: 1 transmit, 0 receive |
| sa_o | output | 5 | Subaddress of the accepted command |
| wc_o | output | 5 | Raw count field or mode code |
| wcnt_o | output | 6 | Decoded word count (1..32, 0 for mode) |
| kind_o | output | 2 | 0 receive data, 1 transmit data, 2 mode |
| bcast_o | output | 1 | Accepted command was a broadcast |

## Verification
The assertions assume that word_vld_i is a clean single-cycle strobe with word_i and bus_id_i settled in the same cycle. They also assume that bus_id_i names one of the configured buses and that term_addr_i does not change during a message. The stimulus drives every input on the falling clock edge and keeps the terminal address fixed at a value other than 31. It then mixes directed cases with a long random run over own, broadcast and foreign addresses, random done strobes and both bus identifiers.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;
   localparam int unsigned DEF_ADDR_W = 5;
   localparam int unsigned DEF_SA_W   = 5;
   localparam int unsigned DEF_WC_W   = 5;
   localparam int unsigned DEF_NBUS   = 2;

   typedef enum logic [1:0] {
      KIND_RX   = 2'b00,
      KIND_TX   = 2'b01,
      KIND_MODE = 2'b10
   } cmd_kind_e;
endpackage

// File: rtl/cmdw_field_split.sv
module cmdw_field_split
   import cmdw_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned SA_W   = DEF_SA_W,
   parameter int unsigned WC_W   = DEF_WC_W,
   localparam int unsigned WORD_W = ADDR_W + 1 + SA_W + WC_W
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              tx_o,
   output logic [SA_W-1:0]   sa_o,
   output logic [WC_W-1:0]   wc_o,
   output logic [WC_W:0]     wcnt_o,
   output cmd_kind_e         kind_o
);
   localparam int unsigned SA_LSB   = WC_W;
   localparam int unsigned TX_POS   = WC_W + SA_W;
   localparam int unsigned ADDR_LSB = TX_POS + 1;
   localparam logic [SA_W-1:0] SA_LOW  = '0;
   localparam logic [SA_W-1:0] SA_HIGH = '1;
   localparam logic [WC_W:0]   FULL_CNT = {1'b1, {WC_W{1'b0}}};

   logic is_mode;

   always_comb begin
      addr_o  = word_i[ADDR_LSB +: ADDR_W];
      tx_o    = word_i[TX_POS];
      sa_o    = word_i[SA_LSB +: SA_W];
      wc_o    = word_i[0 +: WC_W];
      is_mode = (sa_o == SA_LOW) || (sa_o == SA_HIGH);
      if (is_mode)
         kind_o = KIND_MODE;
      else if (tx_o)
         kind_o = KIND_TX;
      else
         kind_o = KIND_RX;
      if (is_mode)
         wcnt_o = '0;
      else if (wc_o == '0)
         wcnt_o = FULL_CNT;
      else
         wcnt_o = {1'b0, wc_o};
   end
endmodule

// File: rtl/cmdw_addr_match.sv
module cmdw_addr_match #(
   parameter int unsigned ADDR_W        = 5,
   parameter bit          BCAST_SUPPORT = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] term_addr_i,
   input  logic              bcast_en_i,
   output logic              match_o,
   output logic              bcast_o
);
   localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

   logic own;
   assign own = (addr_i == term_addr_i);

   generate
      if (BCAST_SUPPORT) begin : g_bcast
         logic is_bc;
         assign is_bc   = bcast_en_i && (addr_i == BCAST_ADDR);
         assign match_o = own || is_bc;
         assign bcast_o = is_bc;
      end else begin : g_no_bcast
         logic unused_en;
         assign unused_en = bcast_en_i;
         assign match_o   = own;
         assign bcast_o   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cmdw_msg_ctrl.sv
module cmdw_msg_ctrl #(
   parameter int unsigned SA_W  = 5,
   parameter int unsigned WC_W  = 5,
   parameter int unsigned BUS_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic             done_i,
   input  logic [BUS_W-1:0] bus_id_i,
   input  logic             tx_i,
   input  logic [SA_W-1:0]  sa_i,
   input  logic [WC_W-1:0]  wc_i,
   input  logic [WC_W:0]    wcnt_i,
   input  logic [1:0]       kind_i,
   input  logic             bcast_i,
   output logic             in_cmd_n_o,
   output logic             new_cmd_n_o,
   output logic             abort_o,
   output logic [BUS_W-1:0] bus_sel_o,
   output logic             tx_o,
   output logic [SA_W-1:0]  sa_o,
   output logic [WC_W-1:0]  wc_o,
   output logic [WC_W:0]    wcnt_o,
   output logic [1:0]       kind_o,
   output logic             bcast_o
);
   logic other_bus;
   assign other_bus = (bus_id_i != bus_sel_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cmd_n_o  <= 1'b1;
         new_cmd_n_o <= 1'b1;
         abort_o     <= 1'b0;
         bus_sel_o   <= '0;
         tx_o        <= 1'b0;
         sa_o        <= '0;
         wc_o        <= '0;
         wcnt_o      <= '0;
         kind_o      <= '0;
         bcast_o     <= 1'b0;
      end else begin
         new_cmd_n_o <= !hit_i;
         abort_o     <= hit_i && !in_cmd_n_o && other_bus;
         if (hit_i) begin
            in_cmd_n_o <= 1'b0;
            bus_sel_o  <= bus_id_i;
            tx_o       <= tx_i;
            sa_o       <= sa_i;
            wc_o       <= wc_i;
            wcnt_o     <= wcnt_i;
            kind_o     <= kind_i;
            bcast_o    <= bcast_i;
         end else if (done_i) begin
            in_cmd_n_o <= 1'b1;
         end
      end
   end

   AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> (!new_cmd_n_o && !in_cmd_n_o)); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_i |=> (new_cmd_n_o && !abort_o && $stable(bus_sel_o) && $stable(sa_o))); // R4
   AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_cmd_n_o && !hit_i) |=> ($stable(tx_o) && $stable(sa_o) && $stable(wc_o) && $stable(wcnt_o))); // R5
   AST_MODE_NOCNT: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_o == 2'b10) |-> (wcnt_o == '0)); // R7
   AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !hit_i) |=> in_cmd_n_o); // R8
   AST_ABORT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> ($past(hit_i) && !$past(in_cmd_n_o) && (bus_sel_o != $past(bus_sel_o)))); // R9
   AST_DONE_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && hit_i) |=> !in_cmd_n_o); // R11
endmodule

// File: rtl/cmdw_decoder.sv
module cmdw_decoder
   import cmdw_pkg::*;
#(
   parameter int unsigned ADDR_W        = DEF_ADDR_W,
   parameter int unsigned SA_W          = DEF_SA_W,
   parameter int unsigned WC_W          = DEF_WC_W,
   parameter int unsigned NBUS          = DEF_NBUS,
   parameter bit          BCAST_SUPPORT = 1'b1,
   localparam int unsigned WORD_W = ADDR_W + 1 + SA_W + WC_W,
   localparam int unsigned BUS_W  = (NBUS > 1) ? $clog2(NBUS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [BUS_W-1:0]  bus_id_i,
   input  logic [ADDR_W-1:0] term_addr_i,
   input  logic              bcast_en_i,
   input  logic              msg_done_i,
   output logic              in_cmd_n_o,
   output logic              new_cmd_n_o,
   output logic              abort_o,
   output logic [BUS_W-1:0]  bus_sel_o,
   output logic              tx_o,
   output logic [SA_W-1:0]   sa_o,
   output logic [WC_W-1:0]   wc_o,
   output logic [WC_W:0]     wcnt_o,
   output logic [1:0]        kind_o,
   output logic              bcast_o
);
   generate
      if (NBUS < 2) begin : g_bad_nbus
         $error("cmdw_decoder: a redundant bus needs NBUS >= 2");
      end
      if (ADDR_W < 2 || SA_W < 2 || WC_W < 1) begin : g_bad_width
         $error("cmdw_decoder: field widths too small");
      end
   endgenerate

   logic [ADDR_W-1:0] f_addr;
   logic              f_tx;
   logic [SA_W-1:0]   f_sa;
   logic [WC_W-1:0]   f_wc;
   logic [WC_W:0]     f_wcnt;
   cmd_kind_e         f_kind;
   logic              m_match;
   logic              m_bcast;
   logic              hit;

   cmdw_field_split #(
      .ADDR_W (ADDR_W),
      .SA_W   (SA_W),
      .WC_W   (WC_W)
   ) split_i (
      .word_i (word_i),
      .addr_o (f_addr),
      .tx_o   (f_tx),
      .sa_o   (f_sa),
      .wc_o   (f_wc),
      .wcnt_o (f_wcnt),
      .kind_o (f_kind)
   );

   cmdw_addr_match #(
      .ADDR_W        (ADDR_W),
      .BCAST_SUPPORT (BCAST_SUPPORT)
   ) match_i (
      .addr_i      (f_addr),
      .term_addr_i (term_addr_i),
      .bcast_en_i  (bcast_en_i),
      .match_o     (m_match),
      .bcast_o     (m_bcast)
   );

   assign hit = word_vld_i && m_match;

   cmdw_msg_ctrl #(
      .SA_W  (SA_W),
      .WC_W  (WC_W),
      .BUS_W (BUS_W)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (hit),
      .done_i      (msg_done_i),
      .bus_id_i    (bus_id_i),
      .tx_i        (f_tx),
      .sa_i        (f_sa),
      .wc_i        (f_wc),
      .wcnt_i      (f_wcnt),
      .kind_i      (f_kind),
      .bcast_i     (m_bcast),
      .in_cmd_n_o  (in_cmd_n_o),
      .new_cmd_n_o (new_cmd_n_o),
      .abort_o     (abort_o),
      .bus_sel_o   (bus_sel_o),
      .tx_o        (tx_o),
      .sa_o        (sa_o),
      .wc_o        (wc_o),
      .wcnt_o      (wcnt_o),
      .kind_o      (kind_o),
      .bcast_o     (bcast_o)
   );
endmodule

// File: tb/cmdw_decoder_tb_top.sv
`timescale 1ns/1ps
module cmdw_decoder_tb_top;
   localparam int TERM = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_vld_i = 1'b0;
   logic [15:0] word_i = '0;
   logic        bus_id_i = 1'b0;
   logic [4:0]  term_addr_i = 5'(TERM);
   logic        bcast_en_i = 1'b0;
   logic        msg_done_i = 1'b0;
   logic        in_cmd_n_o, new_cmd_n_o, abort_o, bus_sel_o, tx_o, bcast_o;
   logic [4:0]  sa_o, wc_o;
   logic [5:0]  wcnt_o;
   logic [1:0]  kind_o;

   cmdw_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld_i), .word_i(word_i),
      .bus_id_i(bus_id_i), .term_addr_i(term_addr_i), .bcast_en_i(bcast_en_i),
      .msg_done_i(msg_done_i), .in_cmd_n_o(in_cmd_n_o), .new_cmd_n_o(new_cmd_n_o),
      .abort_o(abort_o), .bus_sel_o(bus_sel_o), .tx_o(tx_o), .sa_o(sa_o),
      .wc_o(wc_o), .wcnt_o(wcnt_o), .kind_o(kind_o), .bcast_o(bcast_o)
   );

   always #2.5 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;
   string scen = "R1";

   // behavioural reference model
   int m_in = 1, m_new = 1, m_abort = 0, m_bus = 0, m_tx = 0, m_sa = 0;
   int m_wc = 0, m_wcnt = 0, m_kind = 0, m_bc = 0;

   always @(posedge clk) begin
      int a, s, w;
      bit acc, isbc;
      if (!rst_n) begin
         m_in = 1; m_new = 1; m_abort = 0; m_bus = 0; m_tx = 0; m_sa = 0;
         m_wc = 0; m_wcnt = 0; m_kind = 0; m_bc = 0;
      end else begin
         a = int'(word_i[15:11]);
         s = int'(word_i[9:5]);
         w = int'(word_i[4:0]);
         isbc = bcast_en_i && (a == 31);
         acc = word_vld_i && ((a == TERM) || isbc);
         m_abort = (acc && m_in == 0 && int'(bus_id_i) != m_bus) ? 1 : 0;
         m_new = acc ? 0 : 1;
         if (acc) begin
            m_in = 0;
            m_bus = int'(bus_id_i);
            m_tx = int'(word_i[10]);
            m_sa = s;
            m_wc = w;
            m_bc = isbc ? 1 : 0;
            if (s == 0 || s == 31) begin
               m_kind = 2; m_wcnt = 0;
            end else begin
               m_kind = m_tx;
               m_wcnt = (w == 0) ? 32 : w;
            end
         end else if (msg_done_i) begin
            m_in = 1;
         end
      end
   end

   task automatic chk(input int act, input int exp, input string tag);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, scen, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         chk(int'(in_cmd_n_o),  m_in,    "R2 in_cmd_n");
         chk(int'(new_cmd_n_o), m_new,   "R2 new_cmd_n");
         chk(int'(abort_o),     m_abort, "R9 abort");
         chk(int'(bus_sel_o),   m_bus,   "R9 bus_sel");
         chk(int'(tx_o),        m_tx,    "R5 tx");
         chk(int'(sa_o),        m_sa,    "R5 sa");
         chk(int'(wc_o),        m_wc,    "R5 wc");
         chk(int'(wcnt_o),      m_wcnt,  "R7 wcnt");
         chk(int'(kind_o),      m_kind,  "R6 kind");
         chk(int'(bcast_o),     m_bc,    "R3 bcast");
      end
   end

   task automatic send(input bit bus, input int addr, input bit tx, input int sa,
                       input int wc, input bit vld, input bit done);
      @(negedge clk);
      #0.1;
      word_i     = {5'(addr), tx, 5'(sa), 5'(wc)};
      bus_id_i   = bus;
      word_vld_i = vld;
      msg_done_i = done;
      @(negedge clk);
      #0.1;
      word_vld_i = 1'b0;
      msg_done_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      scen = "R1 reset";
      idle(4);
      #0.1 rst_n = 1'b1;
      scen = "R2 own receive";      send(0, TERM, 0, 3, 5, 1, 0); idle(2);
      scen = "R4 foreign addr";     send(1, 4, 1, 7, 2, 1, 0); idle(2);
      scen = "R4 no strobe";        send(1, TERM, 1, 8, 9, 0, 0); idle(2);
      scen = "R8 done";             send(0, 0, 0, 0, 0, 0, 1); idle(2);
      scen = "R7 zero count";       send(0, TERM, 1, 12, 0, 1, 0); idle(1);
      scen = "R6 mode sa0";         send(0, TERM, 1, 0, 17, 1, 0); idle(1);
      scen = "R6 mode sa31";        send(0, TERM, 0, 31, 2, 1, 0); idle(1);
      scen = "R8 done2";            send(0, 0, 0, 0, 0, 0, 1); idle(1);
      scen = "R3 bcast off";        bcast_en_i = 0; send(0, 31, 0, 5, 4, 1, 0); idle(1);
      scen = "R3 bcast on";         bcast_en_i = 1; send(0, 31, 0, 5, 4, 1, 0); idle(1);
      scen = "R9 other bus active"; send(1, TERM, 1, 6, 3, 1, 0); idle(1);
      scen = "R10 same bus active"; send(1, TERM, 0, 2, 1, 1, 0); idle(1);
      scen = "R8 done3";            send(0, 0, 0, 0, 0, 0, 1); idle(1);
      scen = "R10 other bus idle";  send(0, TERM, 0, 9, 31, 1, 0); idle(1);
      scen = "R11 done with hit";   send(1, TERM, 1, 14, 8, 1, 1); idle(2);
      scen = "R4 mixed random";
      for (int i = 0; i < 2000; i++) begin
         int pick;
         int ad;
         pick = $urandom_range(0, 3);
         ad = (pick == 0) ? TERM : (pick == 1) ? 31 : int'($urandom_range(0, 30));
         if (i % 97 == 0) bcast_en_i = ~bcast_en_i;
         send(1'($urandom_range(0, 1)), ad, 1'($urandom_range(0, 1)),
              int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
      end
      idle(3);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule